// File: doc/BRIEF.md
# Supervisor Reset Sequencer

This block turns digital supply-status signals and a push-button input into a clean system reset. Two comparator results arrive as already-synchronized levels: `vcc_ok` says the main supply sits above its trip point, and `v2_ok` says a second monitored rail does. While the main supply is low, or while the manual reset button is held, the system reset is driven active. It stays active for a selectable hold-off time once the cause has gone away.

All delays are counted in milliseconds. A prescaler derives the millisecond tick from the system clock. The manual reset input passes through a two-flop synchronizer and a glitch filter, so short spikes on the button line never reach the reset output. The two supply flags are forwarded with no hold-off at all, so software can read an early power-fail warning. The reset is offered in both polarities.

Top module: `supervisor_reset_seq`

## Requirements
- R1: While `vcc_ok` is low, `sys_rst_n` is 0 from the next clock on.
- R2: `sys_rst_n` returns to 1 only after the assertion cause has been absent for the selected number of milliseconds. A millisecond is CLK_PER_MS clocks. Release falls at least (delay-1) ms and at most delay ms plus two clocks after the cause clears.
- R3: `dly_sel` encodes the hold-off: 2'b00 = 50 ms, 2'b01 = 200 ms, 2'b10 = 400 ms, 2'b11 = 800 ms. The value is captured on every clock in which a cause is present. The last captured value governs the following count, even if the pin changes during it.
- R4: After `rst`, the captured selection is 2'b01 (200 ms). So if no cause appears, the first release takes 200 ms whatever `dly_sel` shows.
- R5: A low on `mr_n` that lasts at least MR_FILT_CYC clocks asserts reset. Reset stays asserted while the pin stays low and for the selected delay after the pin goes high again.
- R6: A low pulse on `mr_n` shorter than MR_FILT_CYC clocks has no effect on `sys_rst_n`.
- R7: `vcc_low_n` equals `vcc_ok` in the same cycle, with no delay.
- R8: `v2_fail_n` equals `v2_ok` in the same cycle, with no delay.
- R9: `sys_rst` is always the inverse of `sys_rst_n`.
- R10: If `vcc_ok` drops while the hold-off is being counted, the count starts again from zero at the next rise.
- R11: While `rst` is high, `sys_rst_n` is 0. The millisecond tick comes from a free-running prescaler that fires once every CLK_PER_MS clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_ok | input | 1 | Main supply above first trip point (synchronized) |
| v2_ok | input | 1 | Second supply above its trip point (synchronized) |
| mr_n | input | 1 | Manual reset button, active low, asynchronous |
| dly_sel | input | 2 | Hold-off selection (see R3) |
| sys_rst_n | output | 1 | System reset, active low |
| sys_rst | output | 1 | System reset, active high |
| vcc_low_n | output | 1 | Early main-supply-low flag, active low |
| v2_fail_n | output | 1 | Second-supply fail flag, active low |

## Verification
The main release function is driven with four kinds of stimulus.
- A clean power-up after `rst` separates the default selection from the pin value.
- Supply drops with each of the four selections separate the delay encodings from each other.
- A drop in the middle of a count shows whether the count restarts or resumes.
- Long and short presses of the button show whether stretching and glitch rejection are handled at the filter threshold.

A behavioural model follows every clock. It catches off-by-one-tick errors that the windowed checks would let through.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        DLY_50MS  = 2'b00,
        DLY_200MS = 2'b01,
        DLY_400MS = 2'b10,
        DLY_800MS = 2'b11
    } dly_sel_e;

    localparam int unsigned DLY_MAX_MS = 800;
    localparam int unsigned MS_W       = $clog2(DLY_MAX_MS + 1);

    typedef struct packed {
        logic            active;
        logic [MS_W-1:0] ms;
        dly_sel_e        sel;
    } seq_state_t;

    function automatic logic [MS_W-1:0] dly_ms(dly_sel_e s);
        case (s)
            DLY_50MS:  return MS_W'(50);
            DLY_200MS: return MS_W'(200);
            DLY_400MS: return MS_W'(400);
            default:   return MS_W'(800);
        endcase
    endfunction

endpackage

// File: rtl/sup_ms_tick.sv
module sup_ms_tick #(
    parameter int unsigned CLK_PER_MS = 50000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned PW = $clog2(CLK_PER_MS + 1);

    logic [PW-1:0] pcnt_q;
    logic          tick_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            tick_q <= 1'b0;
        end else if (pcnt_q == PW'(CLK_PER_MS - 1)) begin
            pcnt_q <= '0;
            tick_q <= 1'b1;
        end else begin
            pcnt_q <= pcnt_q + 1'b1;
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R11: a tick is issued exactly when the prescaler wraps
    a_r11_tick_on_wrap: assert property (@(posedge clk) disable iff (rst)
        tick_q |-> (pcnt_q == '0));

endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
    parameter int unsigned FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic mr_n_raw,
    output logic mr_n_clean
);
    localparam int unsigned CW = $clog2(FILT_CYC + 1);

    logic          s1_q, s2_q;
    logic          filt_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b1;
            s2_q <= 1'b1;
        end else begin
            s1_q <= mr_n_raw;
            s2_q <= s1_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q <= 1'b1;
            cnt_q  <= '0;
        end else if (s2_q == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_CYC - 1)) begin
            filt_q <= s2_q;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign mr_n_clean = filt_q;

    // R6: the filtered level only moves after a full run of differing samples
    a_r6_filter_run: assert property (@(posedge clk) disable iff (rst)
        !$stable(filt_q) |-> ($past(cnt_q) == CW'(FILT_CYC - 1)));

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer
    import sup_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hold,
    input  logic     tick,
    input  dly_sel_e sel_in,
    output logic     rst_act
);
    seq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (hold) begin
            st_d.active = 1'b1;
            st_d.ms     = '0;
            st_d.sel    = sel_in;
        end else if (st_q.active && tick) begin
            st_d.ms = st_q.ms + 1'b1;
            if (st_d.ms == dly_ms(st_q.sel))
                st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.active <= 1'b1;
            st_q.ms     <= '0;
            st_q.sel    <= DLY_200MS;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_act = st_q.active;

    // R10: any cause present clears the millisecond count
    a_r10_restart: assert property (@(posedge clk) disable iff (rst)
        hold |=> (st_q.ms == '0));

    // R2: release only happens on a millisecond boundary
    a_r2_release_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.active) |-> $past(tick));

endmodule

// File: rtl/supervisor_reset_seq.sv
module supervisor_reset_seq
    import sup_pkg::*;
#(
    parameter int unsigned CLK_PER_MS  = 50000,
    parameter int unsigned MR_FILT_CYC = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vcc_ok,
    input  logic       v2_ok,
    input  logic       mr_n,
    input  logic [1:0] dly_sel,
    output logic       sys_rst_n,
    output logic       sys_rst,
    output logic       vcc_low_n,
    output logic       v2_fail_n
);
    logic tick;
    logic mr_clean_n;
    logic hold;
    logic rst_act;

    sup_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sup_mr_filter #(.FILT_CYC(MR_FILT_CYC)) u_mr (
        .clk        (clk),
        .rst        (rst),
        .mr_n_raw   (mr_n),
        .mr_n_clean (mr_clean_n)
    );

    assign hold = !vcc_ok || !mr_clean_n;

    sup_hold_timer u_hold (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .tick    (tick),
        .sel_in  (dly_sel_e'(dly_sel)),
        .rst_act (rst_act)
    );

    assign sys_rst_n = !rst_act;
    assign sys_rst   = rst_act;
    assign vcc_low_n = vcc_ok;
    assign v2_fail_n = v2_ok;

    // R1: a low supply forces reset on the following cycle
    a_r1_supply_low: assert property (@(posedge clk) disable iff (rst)
        !vcc_ok |=> !sys_rst_n);

    // R5: a filtered button press forces reset on the following cycle
    a_r5_button_held: assert property (@(posedge clk) disable iff (rst)
        !mr_clean_n |=> sys_rst);

endmodule

// File: tb/supervisor_reset_seq_tb.sv
module supervisor_reset_seq_tb;
    localparam int N = 4;
    localparam int F = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vcc_ok = 1'b1, v2_ok = 1'b1, mr_n = 1'b1;
    logic [1:0] dly_sel = 2'b00;
    logic sys_rst_n, sys_rst, vcc_low_n, v2_fail_n;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    supervisor_reset_seq #(.CLK_PER_MS(N), .MR_FILT_CYC(F)) u_dut (
        .clk(clk), .rst(rst), .vcc_ok(vcc_ok), .v2_ok(v2_ok), .mr_n(mr_n),
        .dly_sel(dly_sel), .sys_rst_n(sys_rst_n), .sys_rst(sys_rst),
        .vcc_low_n(vcc_low_n), .v2_fail_n(v2_fail_n));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lim_ms(input int s);
        if (s == 0) return 50;
        if (s == 1) return 200;
        if (s == 2) return 400;
        return 800;
    endfunction

    // behavioural reference model
    int k, m_tick, m_s1, m_s2, m_f, m_run, m_ms, m_rst, m_sel;
    always @(posedge clk) begin
        int hold;
        if (rst) begin
            k = 0; m_tick = 0; m_s1 = 1; m_s2 = 1; m_f = 1; m_run = 0;
            m_ms = 0; m_rst = 1; m_sel = 1;
        end else begin
            k++;
            hold = (!vcc_ok || m_f == 0) ? 1 : 0;
            if (hold != 0) begin
                m_ms = 0; m_rst = 1; m_sel = int'(dly_sel);
            end else if (m_rst != 0 && m_tick != 0) begin
                m_ms++;
                if (m_ms >= lim_ms(m_sel)) m_rst = 0;
            end
            if (m_s2 == m_f) m_run = 0;
            else if (m_run + 1 >= F) begin m_f = m_s2; m_run = 0; end
            else m_run++;
            m_s2 = m_s1;
            m_s1 = int'(mr_n);
            m_tick = (k % N == 0) ? 1 : 0;
        end
        #5;
        check(sys_rst_n == !m_rst, "R2 model sys_rst_n", int'(sys_rst_n), m_rst == 0 ? 1 : 0);
        check(sys_rst == !sys_rst_n, "R9 polarity", int'(sys_rst), int'(!sys_rst_n));
        check(vcc_low_n == vcc_ok, "R7 vcc flag", int'(vcc_low_n), int'(vcc_ok));
        check(v2_fail_n == v2_ok, "R8 v2 flag", int'(v2_fail_n), int'(v2_ok));
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rst(input bit asserted, input string tag);
        check(sys_rst_n == !asserted, tag, int'(sys_rst_n), int'(!asserted));
    endtask

    initial begin
        cyc(4);
        expect_rst(1, "R11 reset state");
        rst = 1'b0;
        // R4: default 200 ms although pin shows 00
        cyc(790); expect_rst(1, "R4 default hold");
        cyc(20);  expect_rst(0, "R4 default release");
        // R8: second flag follows
        v2_ok = 1'b0; cyc(1);
        check(v2_fail_n == 1'b0, "R8 v2 low", int'(v2_fail_n), 0);
        v2_ok = 1'b1; cyc(1);
        // R1 / R7: supply drop
        vcc_ok = 1'b0; dly_sel = 2'b00; cyc(2);
        expect_rst(1, "R1 supply low");
        check(vcc_low_n == 1'b0, "R7 flag low", int'(vcc_low_n), 0);
        cyc(8); vcc_ok = 1'b1;
        cyc(190); expect_rst(1, "R3 50ms hold");
        cyc(20);  expect_rst(0, "R3 50ms release");
        // R10: drop during count
        vcc_ok = 1'b0; cyc(5); vcc_ok = 1'b1; cyc(150);
        vcc_ok = 1'b0; cyc(5); vcc_ok = 1'b1;
        cyc(190); expect_rst(1, "R10 count restarted");
        cyc(20);  expect_rst(0, "R10 release");
        // R3: 400 ms, pin changed during count
        dly_sel = 2'b10; vcc_ok = 1'b0; cyc(5); vcc_ok = 1'b1; cyc(1); dly_sel = 2'b00;
        cyc(1579); expect_rst(1, "R3 400ms hold");
        cyc(30);   expect_rst(0, "R3 400ms release");
        // R3: 800 ms
        dly_sel = 2'b11; vcc_ok = 1'b0; cyc(5); vcc_ok = 1'b1;
        cyc(3180); expect_rst(1, "R3 800ms hold");
        cyc(30);   expect_rst(0, "R3 800ms release");
        // R6: short glitch ignored
        dly_sel = 2'b00;
        mr_n = 1'b0; cyc(2); mr_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            cyc(1); expect_rst(0, "R6 glitch ignored");
        end
        // R5: long press stretched
        mr_n = 1'b0; cyc(10); expect_rst(1, "R5 button held");
        cyc(10); mr_n = 1'b1;
        cyc(150); expect_rst(1, "R5 stretch after release");
        cyc(65);  expect_rst(0, "R5 release after delay");
        cyc(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule